// File: doc/BRIEF.md
# Storage Key Reference/Change Updater

This block keeps one 7-bit storage key per 4 KiB page frame in a small on-chip array and updates it whenever a new address translation is installed. The caller presents an absolute address, the kind of access (load, store or instruction fetch) and the permission set the translation would grant. The block reads the key of the addressed frame, marks the frame as referenced, marks it as changed on a store, and writes the key back only when it actually changed. It returns the permission set, adjusted so that a read of a frame not yet marked changed grants no write permission. The first later store then misses and comes back through this block to set the change bit.

A global enable gates all key activity. While it is low the array is not touched and permissions pass through as given. A frame number beyond the array counts as a key read error, which also leaves keys and permissions alone. A host write port sets keys directly, and a combinational peek port reads them back. A request takes one read cycle and one write-back cycle, and a new request may enter every cycle.

Top module: `skey_rc_updater`

## Requirements
- R1: When `keys_en` is low at the request, no key is written and `perm_out` equals `req_perm`.
- R2: For any kind other than store (`req_kind` 0 = load, 2 = fetch, 3 = treated as load) with the key's change bit clear, the write permission bit (`perm` bit 1; bit 0 = read, bit 2 = execute) is cleared in `perm_out`. The other permission bits are copied.
- R3: A store (`req_kind` = 1) sets the change bit (key bit 1) and never removes permissions.
- R4: Every enabled, error-free access sets the reference bit (key bit 2).
- R5: The key is written back only when the updated value differs from the value read. A host write to the same frame at the read edge therefore survives when no update is needed.
- R6: The frame index is `req_addr >> 12`. An index at or beyond `NUM_PAGES` is a read error: no key is written and `perm_out` equals `req_perm`.
- R7: The key layout is [6:3] access-control key, [2] reference, [1] change, [0] fetch-protect. An update preserves bits 6:3 and 0.
- R8: A request sampled at clock edge k gives `done` low after edge k and a one-cycle `done` pulse after edge k+1, with `perm_out` valid alongside it.
- R9: A host write and an update write-back to the same frame at the same edge leave the host's value.
- R10: Reset clears `done`, `perm_out` and every key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_en | input | 1 | Global enable for key handling |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Absolute address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_perm | input | 3 | Permission set in: bit0 read, bit1 write, bit2 execute |
| done | output | 1 | Result strobe |
| perm_out | output | 3 | Adjusted permission set |
| host_wr_en | input | 1 | Host key write strobe |
| host_wr_idx | input | IDX_W | Host write frame index |
| host_wr_key | input | 7 | Host write key value |
| peek_idx | input | IDX_W | Frame index to observe |
| peek_key | output | 7 | Current key of `peek_idx` |

## Verification
Two functions can land on the same frame in one cycle: the host write port and the updater's own array accesses. The bench provokes the collision in two ways. In the first, the host writes at the edge where the updater reads. The final key then shows whether a write-back happened at all: a key that needed no change keeps the host value, and one that needed a change carries the value computed from the old key. In the second, the host writes at the write-back edge itself, and the host value must win. All of this is judged through the peek port.

// File: rtl/skey_pkg.sv
`timescale 1ns/1ps
package skey_pkg;
  localparam int KEY_W   = 7;
  localparam int PERM_W  = 3;
  localparam int REF_BIT = 2;
  localparam int CHG_BIT = 1;
  localparam int PERM_WR = 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  function automatic logic [KEY_W-1:0] key_after(input logic [KEY_W-1:0] key,
                                                 input logic [1:0] kind);
    logic [KEY_W-1:0] k;
    k = key;
    k[REF_BIT] = 1'b1;
    if (kind == ACC_STORE) k[CHG_BIT] = 1'b1;
    return k;
  endfunction

  function automatic logic [PERM_W-1:0] perm_after(input logic [PERM_W-1:0] perm,
                                                   input logic [KEY_W-1:0] key,
                                                   input logic [1:0] kind);
    logic [PERM_W-1:0] p;
    p = perm;
    if (kind != ACC_STORE && !key[CHG_BIT]) p[PERM_WR] = 1'b0;
    return p;
  endfunction
endpackage

// File: rtl/skey_store.sv
`timescale 1ns/1ps
module skey_store #(
  parameter int DEPTH = 64,
  parameter int KW    = 7,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [KW-1:0] rd_key,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [KW-1:0] upd_key,
  input  logic          host_en,
  input  logic [IW-1:0] host_idx,
  input  logic [KW-1:0] host_key,
  input  logic [IW-1:0] peek_idx,
  output logic [KW-1:0] peek_key
);
  logic [KW-1:0] mem [DEPTH];

  // host write placed last so it wins a same-frame collision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (upd_en)  mem[upd_idx]  <= upd_key;
      if (host_en) mem[host_idx] <= host_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_key <= '0;
    else if (rd_en) rd_key <= mem[rd_idx];
  end

  assign peek_key = mem[peek_idx];
endmodule

// File: rtl/skey_rc_logic.sv
`timescale 1ns/1ps
module skey_rc_logic
  import skey_pkg::*;
(
  input  logic              active,
  input  logic [1:0]        kind,
  input  logic [KEY_W-1:0]  old_key,
  input  logic [PERM_W-1:0] perm_in,
  output logic [KEY_W-1:0]  new_key,
  output logic [PERM_W-1:0] perm_res,
  output logic              need_wb
);
  always_comb begin
    new_key  = key_after(old_key, kind);
    perm_res = active ? perm_after(perm_in, old_key, kind) : perm_in;
    need_wb  = active && (new_key != old_key);
  end
endmodule

// File: rtl/skey_rc_updater.sv
`timescale 1ns/1ps
module skey_rc_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_PAGES  = 64,
  localparam int IDX_W     = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int PFN_W     = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keys_en,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic [2:0]        req_perm,
  output logic              done,
  output logic [2:0]        perm_out,
  input  logic              host_wr_en,
  input  logic [IDX_W-1:0]  host_wr_idx,
  input  logic [6:0]        host_wr_key,
  input  logic [IDX_W-1:0]  peek_idx,
  output logic [6:0]        peek_key
);
  // request decode
  logic [PFN_W-1:0] req_pfn;
  logic             req_oob;
  logic             rd_fire;
  assign req_pfn = req_addr[ADDR_W-1:PAGE_SHIFT];
  assign req_oob = (req_pfn >= PFN_W'(NUM_PAGES));
  assign rd_fire = req_valid && keys_en && !req_oob;

  // stage registers (the read-to-write-back cycle)
  logic              stg_valid, stg_en, stg_err;
  logic [1:0]        stg_kind;
  logic [PERM_W-1:0] stg_perm;
  logic [IDX_W-1:0]  stg_idx;
  logic [KEY_W-1:0]  stg_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_valid <= 1'b0;
      stg_en    <= 1'b0;
      stg_err   <= 1'b0;
      stg_kind  <= ACC_LOAD;
      stg_perm  <= '0;
      stg_idx   <= '0;
    end else begin
      stg_valid <= req_valid;
      if (req_valid) begin
        stg_en   <= keys_en;
        stg_err  <= req_oob;
        stg_kind <= req_kind;
        stg_perm <= req_perm;
        stg_idx  <= req_pfn[IDX_W-1:0];
      end
    end
  end

  // named events for the checker
  logic             stg_active;
  logic             wb_fire;
  logic             wb_need;
  logic [KEY_W-1:0] wb_key;
  logic [2:0]       perm_next;
  assign stg_active = stg_valid && stg_en && !stg_err;
  assign wb_fire    = stg_valid && wb_need;

  skey_store #(.DEPTH(NUM_PAGES), .KW(KEY_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_fire),
    .rd_idx   (req_pfn[IDX_W-1:0]),
    .rd_key   (stg_key),
    .upd_en   (wb_fire),
    .upd_idx  (stg_idx),
    .upd_key  (wb_key),
    .host_en  (host_wr_en),
    .host_idx (host_wr_idx),
    .host_key (host_wr_key),
    .peek_idx (peek_idx),
    .peek_key (peek_key)
  );

  skey_rc_logic logic_i (
    .active   (stg_active),
    .kind     (stg_kind),
    .old_key  (stg_key),
    .perm_in  (stg_perm),
    .new_key  (wb_key),
    .perm_res (perm_next),
    .need_wb  (wb_need)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      perm_out <= '0;
    end else begin
      done <= stg_valid;
      if (stg_valid) perm_out <= perm_next;
    end
  end
endmodule

// File: rtl/skey_rc_checker.sv
`timescale 1ns/1ps
module skey_rc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stg_valid,
  input logic       stg_en,
  input logic       stg_err,
  input logic [1:0] stg_kind,
  input logic [2:0] stg_perm,
  input logic [6:0] stg_key,
  input logic       wb_fire,
  input logic [6:0] wb_key,
  input logic       done,
  input logic [2:0] perm_out
);
  a_r1_off_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && !stg_en) |-> !wb_fire);
  a_r6_err_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && stg_err) |-> !wb_fire);
  a_r1_perm_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && (!stg_en || stg_err)) |=> (perm_out == $past(stg_perm)));
  a_r2_read_revoke: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid && stg_en && !stg_err && stg_kind != 2'd1 && !stg_key[1]) |=> !perm_out[1]);
  a_r3_store_chg: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_fire && stg_kind == 2'd1) |-> wb_key[1]);
  a_r4_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> wb_key[2]);
  a_r5_change_only: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> (wb_key != stg_key));
  a_r7_keep_fields: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |-> ({wb_key[6:3], wb_key[0]} == {stg_key[6:3], stg_key[0]}));
  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    stg_valid |=> done);
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(stg_valid));
endmodule

bind skey_rc_updater skey_rc_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stg_valid (stg_valid),
  .stg_en    (stg_en),
  .stg_err   (stg_err),
  .stg_kind  (stg_kind),
  .stg_perm  (stg_perm),
  .stg_key   (stg_key),
  .wb_fire   (wb_fire),
  .wb_key    (wb_key),
  .done      (done),
  .perm_out  (perm_out)
);

// File: tb/skey_rc_updater_tb.sv
`timescale 1ns/1ps
module skey_rc_updater_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        keys_en = 1'b0, req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_perm = '0;
  logic        done;
  logic [2:0]  perm_out;
  logic        host_wr_en = 1'b0;
  logic [5:0]  host_wr_idx = '0, peek_idx = '0;
  logic [6:0]  host_wr_key = '0, peek_key;

  int checks = 0;
  int errs   = 0;

  always #2 clk = ~clk;

  skey_rc_updater dut_i (
    .clk(clk), .rst_n(rst_n), .keys_en(keys_en), .req_valid(req_valid),
    .req_addr(req_addr), .req_kind(req_kind), .req_perm(req_perm),
    .done(done), .perm_out(perm_out), .host_wr_en(host_wr_en),
    .host_wr_idx(host_wr_idx), .host_wr_key(host_wr_key),
    .peek_idx(peek_idx), .peek_key(peek_key)
  );

  typedef struct packed {
    logic       en;
    logic [1:0] kind;
    logic [5:0] page;
    logic [11:0] offs;
    logic [6:0] preset;
    logic [2:0] perm;
    logic [2:0] exp_perm;
    logic [6:0] exp_key;
  } vec_t;

  // kind: 0 load, 1 store, 2 fetch; key [6:3] acc, [2] ref, [1] chg, [0] fp
  localparam vec_t VECS [10] = '{
    '{1'b1, 2'd0, 6'd3,  12'h010, 7'h00, 3'd7, 3'd5, 7'h04},  // R2 R4
    '{1'b1, 2'd1, 6'd4,  12'hFFF, 7'h00, 3'd7, 3'd7, 7'h06},  // R3 R4
    '{1'b1, 2'd2, 6'd5,  12'h000, 7'h02, 3'd7, 3'd7, 7'h06},  // R2 chg set
    '{1'b1, 2'd0, 6'd6,  12'h123, 7'h7F, 3'd7, 3'd7, 7'h7F},  // R5 no change
    '{1'b0, 2'd0, 6'd7,  12'h000, 7'h00, 3'd7, 3'd7, 7'h00},  // R1
    '{1'b1, 2'd2, 6'd35, 12'hABC, 7'h51, 3'd3, 3'd1, 7'h55},  // R7 R6
    '{1'b1, 2'd1, 6'd8,  12'h800, 7'h04, 3'd5, 3'd5, 7'h06},  // R3
    '{1'b0, 2'd1, 6'd12, 12'h004, 7'h30, 3'd6, 3'd6, 7'h30},  // R1
    '{1'b1, 2'd0, 6'd63, 12'h7FF, 7'h06, 3'd2, 3'd2, 7'h06},  // R6 top frame
    '{1'b1, 2'd3, 6'd13, 12'h000, 7'h09, 3'd7, 3'd5, 7'h0D}   // R2 R7 kind 3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_put(input logic [5:0] page, input logic [6:0] key);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_idx = page; host_wr_key = key;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic peek(input logic [5:0] page, output logic [6:0] key);
    peek_idx = page;
    #0.5;
    key = peek_key;
  endtask

  // hw_at: 0 none, 1 host write at read edge, 2 host write at write-back edge
  task automatic issue(input logic en, input logic [1:0] kind, input logic [31:0] addr,
                       input logic [2:0] perm, input int hw_at, input logic [5:0] hw_page,
                       input logic [6:0] hw_key, output logic d1, output logic d2,
                       output logic [2:0] p);
    @(negedge clk);
    keys_en = en; req_kind = kind; req_addr = addr; req_perm = perm; req_valid = 1'b1;
    if (hw_at == 1) begin host_wr_en = 1'b1; host_wr_idx = hw_page; host_wr_key = hw_key; end
    @(negedge clk);
    req_valid = 1'b0; host_wr_en = 1'b0;
    d1 = done;
    if (hw_at == 2) begin host_wr_en = 1'b1; host_wr_idx = hw_page; host_wr_key = hw_key; end
    @(negedge clk);
    host_wr_en = 1'b0;
    d2 = done;
    p  = perm_out;
  endtask

  initial begin
    #(200000 * 4);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic d1, d2;
    logic [2:0] p;
    logic [6:0] k;
    repeat (3) @(negedge clk);
    peek(6'd5, k);
    chk("R10 done after reset", {31'b0, done}, 32'd0);
    chk("R10 perm_out after reset", {29'b0, perm_out}, 32'd0);
    chk("R10 key after reset", {25'b0, k}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      host_put(VECS[i].page, VECS[i].preset);
      issue(VECS[i].en, VECS[i].kind, {14'b0, VECS[i].page, VECS[i].offs},
            VECS[i].perm, 0, 6'd0, 7'd0, d1, d2, p);
      chk("R8 done low after first edge", {31'b0, d1}, 32'd0);
      chk("R8 done pulse", {31'b0, d2}, 32'd1);
      chk("R1 R2 R3 perm_out", {29'b0, p}, {29'b0, VECS[i].exp_perm});
      peek(VECS[i].page, k);
      chk("R3 R4 R7 key after", {25'b0, k}, {25'b0, VECS[i].exp_key});
    end
    @(negedge clk);
    chk("R8 done is a single pulse", {31'b0, done}, 32'd0);

    // R6: frame 64 is out of range; frame 0 aliases in low bits and must stay
    host_put(6'd0, 7'h00);
    issue(1'b1, 2'd0, 32'h0004_0000, 3'd7, 0, 6'd0, 7'd0, d1, d2, p);
    chk("R6 out-of-range perm unchanged", {29'b0, p}, 32'd7);
    peek(6'd0, k);
    chk("R6 out-of-range no key write", {25'b0, k}, 32'd0);

    // R5: host writes at read edge, no update needed -> host value survives
    host_put(6'd9, 7'h06);
    issue(1'b1, 2'd0, 32'h0000_9000, 3'd7, 1, 6'd9, 7'h20, d1, d2, p);
    chk("R5 perm with change set", {29'b0, p}, 32'd7);
    peek(6'd9, k);
    chk("R5 no write-back when unchanged", {25'b0, k}, 32'h20);

    // R5: host writes at read edge, update needed -> write-back from old key
    host_put(6'd10, 7'h00);
    issue(1'b1, 2'd0, 32'h0000_A000, 3'd7, 1, 6'd10, 7'h20, d1, d2, p);
    peek(6'd10, k);
    chk("R5 write-back when changed", {25'b0, k}, 32'h04);

    // R9: host write at write-back edge wins
    host_put(6'd11, 7'h00);
    issue(1'b1, 2'd1, 32'h0000_B000, 3'd7, 2, 6'd11, 7'h38, d1, d2, p);
    peek(6'd11, k);
    chk("R9 host wins collision", {25'b0, k}, 32'h38);

    // R1: disabled store on a fresh frame keeps key and perms
    issue(1'b0, 2'd1, 32'h0000_E000, 3'd1, 0, 6'd0, 7'd0, d1, d2, p);
    chk("R1 disabled perm", {29'b0, p}, 32'd1);
    peek(6'd14, k);
    chk("R1 disabled key untouched", {25'b0, k}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule